// File: doc/BRIEF.md
# Dual-Channel IDE Interrupt Status Unit

This block gathers the interrupt requests of two IDE channels. Each channel raises two kinds of request: one from the attached drive and one when a bus-master transfer completes. Every request is sampled into a status register on each clock. The block exposes those status bits through a small byte-wide host register window. A per-channel mask decides whether a channel can drive the single combined interrupt output. The active level of that output is chosen by a configuration input.

The same window holds a chip-test byte. Software can only write it. It sets the operating mode, either legacy-compatible or native, and a test-mode flag. At one offset, a read and a write reach different storage. At another offset, the read-only status and header flags share a byte with the writable mask bits.

Top module: `ide_irq_status`

## Requirements
- R1: Reading offset 2 returns the channel-0 drive request in bit 0 and the channel-0 bus-master request in bit 1, each as sampled at the previous rising clock edge. Bits 7..2 read 0.
- R2: Reading offset 3 returns the channel-1 drive request in bit 2 and the channel-1 bus-master request in bit 3, each as sampled at the previous rising clock edge. Writes to these bit positions have no effect.
- R3: Bit 0 of offset 3 is the channel-0 mask and bit 1 is the channel-1 mask. A value of 1 means masked. Both reset to 0. A write to offset 3 loads them from wdata[1:0], and they read back in the same positions.
- R4: Bit 4 of offset 3 reads the level of the legacy_hdr input. Writes to offset 3 cannot change it.
- R5: Bits 7..5 of offset 3 always read 0, whatever was written to them.
- R6: A masked channel keeps updating its status bits, but it never makes the combined interrupt active.
- R7: The combined interrupt is active when any unmasked channel has either of its status bits set. irq_out equals that activity when irq_act_low is 0, and its complement when irq_act_low is 1. After reset, with no requests, the interrupt is inactive.
- R8: A write to offset 2 with wdata[7]=1 loads legacy_mode from wdata[1] and test_mode from wdata[0]. Both reset to 0.
- R9: A write to offset 2 with wdata[7]=0 leaves legacy_mode and test_mode unchanged.
- R10: Offsets 0 and 1 read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| drv_irq | input | 2 | Drive interrupt request per channel, active high |
| bm_irq | input | 2 | Bus-master completion request per channel, active high |
| legacy_hdr | input | 1 | Legacy header present flag, reported at offset 3 bit 4 |
| irq_act_low | input | 1 | 1 selects an active-low combined interrupt |
| wr_en | input | 1 | Register write strobe, taken at the rising edge |
| addr | input | 2 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| irq_out | output | 1 | Combined interrupt with selected polarity |
| legacy_mode | output | 1 | Chip-test mode bit: 1 legacy-compatible, 0 native |
| test_mode | output | 1 | Chip-test test-mode flag |

## Verification
Requests and register writes are taken at one rising edge and show up right after it. Status bits, masks and the mode outputs are therefore due one clock after their stimulus. rdata, the header bit and the polarity effect follow their inputs within the same cycle, with no clock between. The bench drives each cycle's stimulus just after a falling edge and updates its model at the rising edge that follows. It compares at the next falling edge, once a fresh read offset has settled. Each comparison thus sees exactly one edge's worth of change.

// File: rtl/ide_irq_pkg.sv
package ide_irq_pkg;

  localparam int unsigned NCH      = 2;
  localparam int unsigned BYTE_W   = 8;
  localparam logic [1:0]  OFS_TEST = 2'd2;
  localparam logic [1:0]  OFS_MASK = 2'd3;

  // status pair per channel: bit0 drive request, bit1 bus-master request
  typedef logic [1:0] st_pair_t;

  function automatic logic [BYTE_W-1:0] status_byte(input st_pair_t ch0);
    return {6'b0, ch0};
  endfunction

  function automatic logic [BYTE_W-1:0] mask_byte(input st_pair_t ch1,
                                                  input logic hdr,
                                                  input logic [NCH-1:0] msk);
    return {3'b000, hdr, ch1, msk};
  endfunction

  function automatic logic irq_level(input logic active, input logic low);
    return active ^ low;
  endfunction

endpackage

// File: rtl/ide_irq_src_latch.sv
module ide_irq_src_latch
  import ide_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     drv_req,
  input  logic     bm_req,
  output st_pair_t st,
  output logic     pend
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= '0;
    else        st <= {bm_req, drv_req};
  end

  assign pend = |st;

  // R1 / R2: a status bit clears once its source has dropped
  a_r1_drv_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv_req) |=> !st[0]);
  a_r2_bm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bm_req) |=> !st[1]);

endmodule

// File: rtl/ide_irq_host_regs.sv
module ide_irq_host_regs
  import ide_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [NCH-1:0]    mask,
  output logic              legacy_mode,
  output logic              test_mode
);

  logic wr_mask, wr_test;
  assign wr_mask = wr_en && (addr == OFS_MASK);
  assign wr_test = wr_en && (addr == OFS_TEST) && wdata[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask        <= '0;
      legacy_mode <= 1'b0;
      test_mode   <= 1'b0;
    end else begin
      if (wr_mask) mask <= wdata[NCH-1:0];
      if (wr_test) begin
        legacy_mode <= wdata[1];
        test_mode   <= wdata[0];
      end
    end
  end

  a_r3_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_MASK) |=> mask == $past(wdata[NCH-1:0]));
  a_r8_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_TEST && wdata[7]) |=>
      {legacy_mode, test_mode} == $past(wdata[1:0]));
  a_r9_key_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_TEST && !wdata[7]) |=> $stable({legacy_mode, test_mode}));
  a_r10_other_ofs: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[1] == 1'b0) |=> $stable({mask, legacy_mode, test_mode}));

endmodule

// File: rtl/ide_irq_status.sv
module ide_irq_status
  import ide_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    drv_irq,
  input  logic [NCH-1:0]    bm_irq,
  input  logic              legacy_hdr,
  input  logic              irq_act_low,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              irq_out,
  output logic              legacy_mode,
  output logic              test_mode
);

  st_pair_t       ch_st   [NCH];
  logic [NCH-1:0] ch_pend;
  logic [NCH-1:0] mask;
  logic           irq_any;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ide_irq_src_latch u_lat (
      .clk     (clk),
      .rst_n   (rst_n),
      .drv_req (drv_irq[c]),
      .bm_req  (bm_irq[c]),
      .st      (ch_st[c]),
      .pend    (ch_pend[c])
    );
  end

  ide_irq_host_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .addr        (addr),
    .wdata       (wdata),
    .mask        (mask),
    .legacy_mode (legacy_mode),
    .test_mode   (test_mode)
  );

  assign irq_any = |(ch_pend & ~mask);
  assign irq_out = irq_level(irq_any, irq_act_low);

  always_comb begin
    case (addr)
      OFS_TEST: rdata = status_byte(ch_st[0]);
      OFS_MASK: rdata = mask_byte(ch_st[1], legacy_hdr, mask);
      default:  rdata = '0;
    endcase
  end

  a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == OFS_MASK) |-> rdata[7:5] == 3'b000);
  a_r4_hdr_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == OFS_MASK) |-> rdata[4] == legacy_hdr);
  a_r6_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> irq_out == irq_act_low);
  a_r7_pending_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_pend[0] && !mask[0]) |-> irq_out != irq_act_low);

endmodule

// File: tb/ide_irq_status_test.sv
module ide_irq_status_test;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] drv_irq = '0, bm_irq = '0;
  logic       legacy_hdr = 1'b0, irq_act_low = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_out, legacy_mode, test_mode;

  int checks = 0, fails = 0;
  bit done = 0;

  // model state
  logic [1:0] m_st0 = '0, m_st1 = '0, m_mask = '0;
  logic       m_leg = 1'b0, m_tst = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ide_irq_status uut (
    .clk(clk), .rst_n(rst_n), .drv_irq(drv_irq), .bm_irq(bm_irq),
    .legacy_hdr(legacy_hdr), .irq_act_low(irq_act_low), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out),
    .legacy_mode(legacy_mode), .test_mode(test_mode)
  );

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    logic [7:0] v = 8'h00;
    if (a == 2'd2) begin v[0] = m_st0[0]; v[1] = m_st0[1]; end
    if (a == 2'd3) begin
      v[0] = m_mask[0]; v[1] = m_mask[1];
      v[2] = m_st1[0];  v[3] = m_st1[1];
      v[4] = legacy_hdr;
    end
    return v;
  endfunction

  function automatic logic exp_irq();
    logic hot = 1'b0;
    if (!m_mask[0] && m_st0 != 2'b00) hot = 1'b1;
    if (!m_mask[1] && m_st1 != 2'b00) hot = 1'b1;
    return irq_act_low ? !hot : hot;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // read one offset and compare everything visible
  task automatic observe(input logic [1:0] a);
    wr_en = 1'b0; addr = a; #1;
    case (a)
      2'd2: chk("R1 status ch0", rdata, exp_read(a));
      2'd3: begin
        chk("R2 status ch1", {6'b0, rdata[3:2]}, {6'b0, exp_read(a)[3:2]});
        chk("R3 mask bits", {6'b0, rdata[1:0]}, {6'b0, m_mask});
        chk("R4 header bit", {7'b0, rdata[4]}, {7'b0, legacy_hdr});
        chk("R5 upper zero", {5'b0, rdata[7:5]}, 8'h00);
      end
      default: chk("R10 unused offset", rdata, 8'h00);
    endcase
    chk((m_mask != 2'b00) ? "R6 masked irq" : "R7 irq level",
        {7'b0, irq_out}, {7'b0, exp_irq()});
    chk("R8 R9 mode bits", {6'b0, legacy_mode, test_mode}, {6'b0, m_leg, m_tst});
  endtask

  // apply stimulus for one clock, update model at the edge
  task automatic cycle(input logic [1:0] d, input logic [1:0] b, input logic we,
                       input logic [1:0] a, input logic [7:0] wd);
    drv_irq = d; bm_irq = b; wr_en = we; addr = a; wdata = wd;
    @(posedge clk);
    m_st0 = {b[0], d[0]};
    m_st1 = {b[1], d[1]};
    if (we && a == 2'd3) m_mask = wd[1:0];
    if (we && a == 2'd2 && wd[7]) begin m_leg = wd[1]; m_tst = wd[0]; end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int seed = 32'h1D3;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    for (int a = 0; a < 4; a++) observe(a[1:0]);

    // R8: valid chip-test write
    cycle(2'b00, 2'b00, 1'b1, 2'd2, 8'h83); observe(2'd2);
    // R9: key bit clear, ignored
    cycle(2'b00, 2'b00, 1'b1, 2'd2, 8'h00); observe(2'd2);
    // R4 R5: try to write header and upper bits
    legacy_hdr = 1'b1;
    cycle(2'b00, 2'b00, 1'b1, 2'd3, 8'hE0); observe(2'd3);
    // R6: both masked, all sources high
    cycle(2'b11, 2'b11, 1'b1, 2'd3, 8'h03); observe(2'd3); observe(2'd2);
    // R2: writes to status bits have no effect
    cycle(2'b00, 2'b00, 1'b1, 2'd3, 8'h0F); observe(2'd3);
    // R7: unmask ch1, bus-master only, active-low
    irq_act_low = 1'b1;
    cycle(2'b00, 2'b10, 1'b1, 2'd3, 8'h01); observe(2'd3);
    // R1: source drop clears status next edge
    cycle(2'b00, 2'b00, 1'b0, 2'd0, 8'h00); observe(2'd3);
    // R10: writes to offsets 0 and 1
    cycle(2'b00, 2'b00, 1'b1, 2'd0, 8'hFF); observe(2'd0);
    cycle(2'b00, 2'b00, 1'b1, 2'd1, 8'hFF); observe(2'd1); observe(2'd3);

    for (int i = 0; i < 600; i++) begin
      legacy_hdr  = 1'($urandom());
      irq_act_low = 1'($urandom());
      cycle(2'($urandom()), 2'($urandom()), 1'(($urandom() % 3) == 0),
            2'($urandom()), 8'($urandom()));
      observe(2'($urandom()));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule